// File: doc/BRIEF.md
# Interrupt priority claim arbiter

This block is the arbitration core of a platform-level interrupt controller. It keeps one pending bit, one claimed bit and a 3-bit priority for every interrupt source, and an enable mask and a threshold for every target context. For each context it drives a level interrupt line. That line is high while at least one source is pending, unclaimed, enabled for the context, and above the context's threshold.

A handler claims by pulsing the claim strobe with a context number. In the same cycle the block returns the winning source ID. On the next clock edge it marks that source claimed and drops its pending bit, so the source takes no further part in arbitration until the handler pulses complete with the same ID. Software configuration arrives on three simple write ports: source priority, context enable mask and context threshold. Source ID 0 means "no interrupt" and is never a candidate.

Top module: `irq_claim_arb`

## Requirements
- R1: A priority write to source ID n (n not 0) stores the low 3 bits of the 8-bit write value as that source's priority, effective from the next clock edge. For example, 0x0E is stored as 6.
- R2: Each source's pending bit takes the level of its request line at every clock edge. A low request clears it and a high request sets it, unless R6 applies.
- R3: A source is eligible for a context when it is pending, not claimed, has its bit set in that context's enable mask, and has a priority strictly greater than that context's threshold. `irq_out[c]` is high exactly when context c has at least one eligible source.
- R4: While `claim_req` is high, `claim_id` in that same cycle shows the eligible source for `claim_ctx` with the highest priority. Among equal priorities the lowest ID wins.
- R5: A claim with no eligible source returns 0 and changes no claimed or pending state beyond R2.
- R6: A claim that returns a nonzero ID clears that source's pending bit and sets its claimed bit at the next edge. The source stays out of arbitration while claimed, even if its request stays high.
- R7: A complete with an 8-bit ID below NSRC clears that source's claimed bit at the next edge. An ID of NSRC or above is ignored.
- R8: A threshold write is stored only if its 8-bit value is at most 7. A larger value leaves the threshold unchanged.
- R9: Source ID 0 is never pending and never wins. Request bit 0 and priority writes to ID 0 have no effect.
- R10: Reset clears all pending, claimed, enable, priority and threshold state, so every interrupt output is low and a claim returns 0.
- R11: The enable mask written for context c (bit n enables source n) applies to context c only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request level per source (bit 0 unused) |
| prio_we | input | 1 | Priority write strobe |
| prio_id | input | IDW | Source ID for the priority write |
| prio_wdata | input | 8 | Priority write value (low 3 bits kept) |
| en_we | input | 1 | Enable mask write strobe |
| en_ctx | input | CW | Context for the enable write |
| en_wdata | input | NSRC | Enable mask, one bit per source |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CW | Context for the threshold write |
| thr_wdata | input | 8 | Threshold value |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CW | Context doing the claim |
| claim_id | output | IDW | Winning source ID, 0 if none |
| cmpl_req | input | 1 | Complete strobe |
| cmpl_id | input | 8 | Source ID being completed |
| irq_out | output | NCTX | Level interrupt per context |

## Verification
The bench builds the block with NSRC = 8 and NCTX = 2. With only seven real sources and eight priority levels, random traffic often produces equal-priority ties and sources that are claimed and still requesting. An 8-bit complete ID against eight sources means out-of-range completes actually occur. Two contexts with different masks show whether an enable or threshold change leaks from one context into the other.

// File: rtl/irq_claim_arb.sv
module irq_claim_arb #(
  parameter int NSRC = 32,
  parameter int NCTX = 4,
  localparam int IDW = $clog2(NSRC),
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            prio_we,
  input  logic [IDW-1:0]  prio_id,
  input  logic [7:0]      prio_wdata,
  input  logic            en_we,
  input  logic [CW-1:0]   en_ctx,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            thr_we,
  input  logic [CW-1:0]   thr_ctx,
  input  logic [7:0]      thr_wdata,
  input  logic            claim_req,
  input  logic [CW-1:0]   claim_ctx,
  output logic [IDW-1:0]  claim_id,
  input  logic            cmpl_req,
  input  logic [7:0]      cmpl_id,
  output logic [NCTX-1:0] irq_out
);
  localparam logic [7:0] MAXP = 8'd7;

  logic [NSRC-1:0] pend_q, clm_q, pend_n, clm_n;
  logic [2:0]      prio_q [NSRC];
  logic [NSRC-1:0] en_q   [NCTX];
  logic [2:0]      thr_q  [NCTX];
  logic [IDW-1:0]  win_id [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [IDW-1:0] best_id;
    logic [2:0]     best_p;
    always_comb begin
      best_id = '0;
      best_p  = thr_q[c];
      for (int i = 1; i < NSRC; i++) begin
        if (pend_q[i] && !clm_q[i] && en_q[c][i] && prio_q[i] > best_p) begin
          best_p  = prio_q[i];
          best_id = IDW'(i);
        end
      end
    end
    assign win_id[c]  = best_id;
    assign irq_out[c] = (best_id != '0);
  end

  assign claim_id = (claim_req && 32'(claim_ctx) < NCTX) ? win_id[claim_ctx] : '0;

  wire cmpl_ok = cmpl_req && (32'(cmpl_id) < NSRC);

  always_comb begin
    pend_n    = src_req;
    pend_n[0] = 1'b0;
    clm_n     = clm_q;
    if (cmpl_ok) clm_n[cmpl_id[IDW-1:0]] = 1'b0;
    if (claim_id != '0) begin
      pend_n[claim_id] = 1'b0;
      clm_n[claim_id]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      clm_q  <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else begin
      pend_q <= pend_n;
      clm_q  <= clm_n;
      if (prio_we && prio_id != '0 && 32'(prio_id) < NSRC)
        prio_q[prio_id] <= prio_wdata[2:0];
      if (en_we && 32'(en_ctx) < NCTX)
        en_q[en_ctx] <= en_wdata;
      if (thr_we && 32'(thr_ctx) < NCTX && thr_wdata <= MAXP)
        thr_q[thr_ctx] <= thr_wdata[2:0];
    end
  end
endmodule

module irq_claim_arb_chk #(
  parameter int NSRC = 32,
  parameter int NCTX = 4,
  localparam int IDW = $clog2(NSRC),
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            claim_req,
  input logic [CW-1:0]   claim_ctx,
  input logic [IDW-1:0]  claim_id,
  input logic            cmpl_req,
  input logic [7:0]      cmpl_id,
  input logic            thr_we,
  input logic [CW-1:0]   thr_ctx,
  input logic [7:0]      thr_wdata,
  input logic [NCTX-1:0] irq_out,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] clm_q,
  input logic [2:0]      prio_q [NSRC],
  input logic [2:0]      thr_q  [NCTX]
);
  a_r4_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && claim_id != '0) |->
      (pend_q[claim_id] && !clm_q[claim_id] && prio_q[claim_id] > thr_q[claim_ctx]));

  a_r3_irq_matches_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && 32'(claim_ctx) < NCTX) |-> ((claim_id != '0) == irq_out[claim_ctx]));

  a_r6_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && claim_id != '0) |=>
      (clm_q[$past(claim_id)] && !pend_q[$past(claim_id)]));

  a_r5_empty_claim_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && claim_id == '0 && !cmpl_req) |=> $stable(clm_q));

  a_r7_complete_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_req && 32'(cmpl_id) < NSRC &&
     !(claim_req && claim_id == cmpl_id[IDW-1:0])) |=> !clm_q[$past(cmpl_id[IDW-1:0])]);

  a_r8_thr_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_we && thr_wdata > 8'd7 && 32'(thr_ctx) < NCTX) |=>
      (thr_q[$past(thr_ctx)] == $past(thr_q[thr_ctx])));

  a_r9_no_src0: assert property (@(posedge clk) disable iff (!rst_n)
    claim_req |-> !(claim_id == '0 && irq_out[claim_ctx] && 32'(claim_ctx) < NCTX));
endmodule

bind irq_claim_arb irq_claim_arb_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
  .clk(clk), .rst_n(rst_n), .claim_req(claim_req), .claim_ctx(claim_ctx),
  .claim_id(claim_id), .cmpl_req(cmpl_req), .cmpl_id(cmpl_id),
  .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_wdata(thr_wdata), .irq_out(irq_out),
  .pend_q(pend_q), .clm_q(clm_q), .prio_q(prio_q), .thr_q(thr_q)
);

// File: tb/sim_irq_claim_arb.sv
`timescale 1ns/1ps
module sim_irq_claim_arb;
  localparam int NSRC = 8;
  localparam int NCTX = 2;
  localparam int IDW = 3;
  localparam int CW = 1;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_req = '0, en_wdata = '0;
  logic prio_we = 0, en_we = 0, thr_we = 0, claim_req = 0, cmpl_req = 0;
  logic [IDW-1:0] prio_id = '0;
  logic [7:0] prio_wdata = '0, thr_wdata = '0, cmpl_id = '0;
  logic [CW-1:0] en_ctx = '0, thr_ctx = '0, claim_ctx = '0;
  logic [IDW-1:0] claim_id;
  logic [NCTX-1:0] irq_out;

  irq_claim_arb #(.NSRC(NSRC), .NCTX(NCTX)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  int mp [NSRC];
  int mpend [NSRC];
  int mclm [NSRC];
  int men [NCTX][NSRC];
  int mthr [NCTX];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mwin(int c);
    int b = 0;
    int bp = mthr[c];
    for (int i = 1; i < NSRC; i++)
      if (mpend[i] != 0 && mclm[i] == 0 && men[c][i] != 0 && mp[i] > bp) begin
        bp = mp[i];
        b = i;
      end
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        mp[i] = 0; mpend[i] = 0; mclm[i] = 0;
        for (int c = 0; c < NCTX; c++) men[c][i] = 0;
      end
      for (int c = 0; c < NCTX; c++) mthr[c] = 0;
    end else begin
      int w;
      w = claim_req ? mwin(int'(claim_ctx)) : 0;
      for (int i = 1; i < NSRC; i++) mpend[i] = int'(src_req[i]);
      if (cmpl_req && int'(cmpl_id) < NSRC) mclm[cmpl_id] = 0;
      if (prio_we && prio_id != 0) mp[prio_id] = int'(prio_wdata) % 8;
      if (en_we) for (int i = 0; i < NSRC; i++) men[en_ctx][i] = int'(en_wdata[i]);
      if (thr_we && thr_wdata <= 7) mthr[thr_ctx] = int'(thr_wdata);
      if (w != 0) begin mpend[w] = 0; mclm[w] = 1; end
    end
  end

  always begin
    @(negedge clk); #5;
    if (rst_n && cmp_on) begin
      for (int c = 0; c < NCTX; c++)
        chk(irq_out[c] == (mwin(c) != 0), "R3 model irq", int'(irq_out[c]), int'(mwin(c) != 0));
      if (claim_req)
        chk(int'(claim_id) == mwin(int'(claim_ctx)), "R4 model claim", int'(claim_id), mwin(int'(claim_ctx)));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    claim_req = 0; cmpl_req = 0; prio_we = 0; en_we = 0; thr_we = 0;
  endtask

  task automatic wr_prio(int id, int v);
    @(negedge clk); prio_we = 1; prio_id = IDW'(id); prio_wdata = 8'(v); tick();
  endtask

  task automatic wr_en(int c, int m);
    @(negedge clk); en_we = 1; en_ctx = CW'(c); en_wdata = NSRC'(m); tick();
  endtask

  task automatic wr_thr(int c, int v);
    @(negedge clk); thr_we = 1; thr_ctx = CW'(c); thr_wdata = 8'(v); tick();
  endtask

  task automatic do_cmpl(int id);
    @(negedge clk); cmpl_req = 1; cmpl_id = 8'(id); tick();
  endtask

  task automatic do_claim(int c, int exp, string tag);
    @(negedge clk); claim_req = 1; claim_ctx = CW'(c); #5;
    chk(int'(claim_id) == exp, tag, int'(claim_id), exp);
    tick();
  endtask

  task automatic exp_irq(int c, int v, string tag);
    @(negedge clk); #5;
    chk(int'(irq_out[c]) == v, tag, int'(irq_out[c]), v);
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    exp_irq(0, 0, "R10 reset irq0");
    exp_irq(1, 0, "R10 reset irq1");
    do_claim(0, 0, "R10 reset claim");
    cmp_on = 1;

    wr_prio(2, 8'h02);
    wr_prio(3, 8'h0D);
    wr_prio(5, 8'h05);
    wr_prio(6, 8'h0E);
    wr_en(0, 8'hFE);
    wr_en(1, 8'h04);
    @(negedge clk); src_req = 8'h6C; tick();
    exp_irq(0, 1, "R2 pending from request");
    do_claim(0, 6, "R1 low bits kept, highest wins");
    do_claim(0, 3, "R4 tie lowest id");
    do_claim(0, 5, "R4 next after masked");
    do_claim(0, 2, "R4 lowest priority last");
    do_claim(0, 0, "R5 nothing eligible");
    exp_irq(0, 0, "R6 claimed masked while requesting");
    exp_irq(1, 0, "R6 claimed masked ctx1");
    do_cmpl(200);
    exp_irq(0, 0, "R7 out-of-range complete ignored");
    do_cmpl(8);
    exp_irq(0, 0, "R7 complete id NSRC ignored");
    do_cmpl(3);
    exp_irq(0, 1, "R7 complete releases source");
    do_claim(1, 0, "R11 ctx1 mask excludes src3");
    do_cmpl(2);
    do_claim(1, 2, "R11 ctx1 picks only enabled source");
    do_cmpl(2);
    wr_thr(0, 5);
    exp_irq(0, 0, "R8 threshold 5 blocks prio 5");
    wr_thr(0, 9);
    exp_irq(0, 0, "R8 threshold 9 ignored");
    exp_irq(1, 1, "R8 ctx1 threshold untouched");
    wr_thr(0, 4);
    do_claim(0, 3, "R8 threshold 4 admits prio 5");

    @(negedge clk); src_req = 8'h00; tick();
    do_cmpl(3); do_cmpl(5); do_cmpl(6);
    exp_irq(0, 0, "R2 low request clears pending");
    exp_irq(1, 0, "R2 low request clears pending ctx1");

    wr_thr(0, 0);
    wr_prio(0, 7);
    wr_en(0, 8'hFF);
    @(negedge clk); src_req = 8'h01; tick();
    exp_irq(0, 0, "R9 source 0 ignored");
    do_claim(0, 0, "R9 source 0 never wins");

    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      src_req = NSRC'($urandom);
      claim_req = ($urandom % 3) == 0;
      claim_ctx = CW'($urandom);
      cmpl_req = ($urandom % 3) == 0;
      cmpl_id = 8'($urandom % 12);
      prio_we = ($urandom % 8) == 0;
      prio_id = IDW'($urandom);
      prio_wdata = 8'($urandom);
      en_we = ($urandom % 16) == 0;
      en_ctx = CW'($urandom);
      en_wdata = NSRC'($urandom);
      thr_we = ($urandom % 12) == 0;
      thr_ctx = CW'($urandom);
      thr_wdata = 8'($urandom % 12);
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule